// File: doc/BRIEF.md
# Intra 16x16 Plane Predictor

This block builds the plane-mode (linear gradient) prediction for a 16x16 luma block. It takes 16 reconstructed samples from the row above, 16 from the column to the left, and the single corner sample above and to the left. All 33 samples are captured on a start pulse. The block then works out a horizontal and a vertical gradient sum with integer weights. From those it scales two slopes, `b` along the row and `c` down the column, and forms an offset `a` from the two far-end neighbours.

The prediction is streamed out as 16 rows of 16 unsigned 8-bit samples, one row per clock. Sixteen column accumulators are loaded once with `a - 7*(b+c) + b*x`. After each row, every accumulator is advanced by `c`. Each output sample is the accumulator rounded down by 5 bits and clipped to 0..255. No multiplier per pixel is needed.

The control is a four-state machine. From `IDLE`, an accepted `start` moves it to `GRAD`. `GRAD` always moves to `COEF`. `COEF` always moves to `ROWS`. `ROWS` stays put until the last row, then returns to `IDLE`. `busy_o` is high in every state except `IDLE`. While `busy_o` is high, `start` is ignored.

Top module: `intra16_plane_pred`

## Requirements
- R1: After reset, `busy_o`, `row_valid_o` and `row_last_o` are all 0.
- R2: A `start` that is high at a clock edge while `busy_o` is 0 is accepted. At the first edge after that one, `busy_o` is 1 and no row is valid. Row 0 becomes visible after the third edge. `busy_o` stays 1 through the last row.
- R3: Exactly 16 rows are produced, on consecutive cycles, with `row_idx_o` running 0 to 15. `row_last_o` is 1 only for row 15. After row 15, `busy_o` returns to 0.
- R4: The horizontal gradient is H = sum over k=1..8 of k*(above[7+k] - above[7-k]), where above[-1] is the corner sample. V is formed the same way from the left samples, also using the corner sample as index -1. Sample i sits at bits [8*i+7 : 8*i] of `above_i` and `left_i`.
- R5: The slopes are b = (5*H + 32) >> 6 and c = (5*V + 32) >> 6. Both are arithmetic shifts on signed values, so negative gradients round toward minus infinity after the +32 bias.
- R6: The offset is a = 16*(above[15] + left[15]). Sample (x, y) equals clip((a + b*(x-7) + c*(y-7) + 16) >> 5). Column x of a row sits at bits [8*x+7 : 8*x] of `row_data_o`.
- R7: Every output sample saturates to the range 0..255. Steep descending gradients give 0, and steep ascending ones give 255.
- R8: Each row differs from the previous one only by adding `c` to every column before rounding, so a flat vertical neighbourhood gives identical rows.
- R9: The neighbour inputs are sampled only when `start` is accepted. A `start` pulse or changed neighbours while `busy_o` is 1 have no effect on the rows being streamed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a new prediction; accepted only while idle |
| above_i | input | 128 | 16 above samples, sample i at bits [8i+7:8i] |
| left_i | input | 128 | 16 left samples, sample i at bits [8i+7:8i] |
| corner_i | input | 8 | Above-left corner sample |
| busy_o | output | 1 | High from the cycle after acceptance through the last row |
| row_valid_o | output | 1 | `row_data_o` carries a prediction row |
| row_last_o | output | 1 | Marks row 15 |
| row_idx_o | output | 4 | Index of the current row |
| row_data_o | output | 128 | 16 predicted samples, column x at bits [8x+7:8x] |

## Verification
The bound checker watches the handshake on every cycle. It checks the three-edge latency to row 0, rows only while busy, row indices that step by one, a last flag only on row 15, and the drop of busy right after it. The arithmetic cannot be seen by a property. Only the bench's scenarios show it: they compare every sample against a direct per-pixel plane formula. The scenarios cover random neighbourhoods, flat blocks, and steep ramps that clip at both 0 and 255. A start pulse with fresh neighbours in the middle of a stream shows that the captured inputs are kept.

// File: rtl/intra16_plane_pkg.sv
package intra16_plane_pkg;
    localparam int unsigned BLK_N    = 16;
    localparam int unsigned SAMPLE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_GRAD = 2'd1,
        ST_COEF = 2'd2,
        ST_ROWS = 2'd3
    } plane_state_e;
endpackage

// File: rtl/plane_grad.sv
module plane_grad #(
    parameter int unsigned N  = 16,
    parameter int unsigned SW = 8,
    parameter int unsigned GW = 15
) (
    input  logic [N*SW-1:0]        samp_i,
    input  logic [SW-1:0]          corner_i,
    output logic signed [GW-1:0]   grad_o
);
    localparam int unsigned HALF = N / 2;

    // ext[0] is the corner, ext[i+1] is sample i
    logic [SW-1:0] ext [0:N];

    always_comb begin
        ext[0] = corner_i;
        for (int i = 0; i < N; i++) begin
            ext[i+1] = samp_i[i*SW +: SW];
        end
    end

    always_comb begin
        logic signed [SW:0]   diff;
        logic signed [GW-1:0] diff_x;
        logic signed [GW-1:0] wt;
        grad_o = '0;
        for (int k = 1; k <= HALF; k++) begin
            diff   = $signed({1'b0, ext[HALF+k]}) - $signed({1'b0, ext[HALF-k]});
            diff_x = GW'(diff);
            wt     = GW'(k);
            grad_o = grad_o + diff_x * wt;
        end
    end
endmodule

// File: rtl/plane_coef.sv
module plane_coef #(
    parameter int unsigned SW  = 8,
    parameter int unsigned GW  = 15,
    parameter int unsigned SLW = 13,
    parameter int unsigned AW  = 20
) (
    input  logic signed [GW-1:0]  h_i,
    input  logic signed [GW-1:0]  v_i,
    input  logic [SW-1:0]         top_end_i,
    input  logic [SW-1:0]         left_end_i,
    output logic signed [SLW-1:0] b_o,
    output logic signed [SLW-1:0] c_o,
    output logic signed [AW-1:0]  base_o
);
    localparam int unsigned PW = GW + 4;

    logic signed [PW-1:0] h_ext, v_ext, h_scaled, v_scaled;
    logic signed [PW-1:0] b_full, c_full;
    logic signed [AW-1:0] a_val, bc_sum, bc7;

    always_comb begin
        h_ext    = PW'(h_i);
        v_ext    = PW'(v_i);
        h_scaled = (h_ext <<< 2) + h_ext + PW'(32);
        v_scaled = (v_ext <<< 2) + v_ext + PW'(32);
        b_full   = h_scaled >>> 6;
        c_full   = v_scaled >>> 6;
        b_o      = $signed(b_full[SLW-1:0]);
        c_o      = $signed(c_full[SLW-1:0]);
    end

    always_comb begin
        a_val  = $signed(AW'({1'b0, top_end_i} + {1'b0, left_end_i})) <<< 4;
        bc_sum = AW'(b_o) + AW'(c_o);
        bc7    = (bc_sum <<< 3) - bc_sum;
        base_o = a_val - bc7;
    end
endmodule

// File: rtl/plane_rowacc.sv
module plane_rowacc #(
    parameter int unsigned N   = 16,
    parameter int unsigned SW  = 8,
    parameter int unsigned SLW = 13,
    parameter int unsigned AW  = 20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_i,
    input  logic                  step_i,
    input  logic signed [AW-1:0]  base_i,
    input  logic signed [SLW-1:0] b_i,
    input  logic signed [SLW-1:0] c_i,
    output logic [N*SW-1:0]       row_o
);
    localparam logic signed [AW-1:0] RND  = AW'(16);
    localparam logic signed [AW-1:0] PMAX = AW'((1 << SW) - 1);

    for (genvar x = 0; x < N; x++) begin : g_col
        localparam int XI = x;
        logic signed [AW-1:0] acc_q;
        logic signed [AW-1:0] shifted;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                acc_q <= '0;
            end else if (load_i) begin
                acc_q <= base_i + AW'(b_i) * AW'(XI);
            end else if (step_i) begin
                acc_q <= acc_q + AW'(c_i);
            end
        end

        always_comb begin
            shifted = (acc_q + RND) >>> 5;
            if (shifted < 0) begin
                row_o[x*SW +: SW] = '0;
            end else if (shifted > PMAX) begin
                row_o[x*SW +: SW] = '1;
            end else begin
                row_o[x*SW +: SW] = shifted[SW-1:0];
            end
        end
    end
endmodule

// File: rtl/intra16_plane_pred.sv
module intra16_plane_pred
    import intra16_plane_pkg::*;
#(
    parameter int unsigned N  = BLK_N,
    parameter int unsigned SW = SAMPLE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [N*SW-1:0]      above_i,
    input  logic [N*SW-1:0]      left_i,
    input  logic [SW-1:0]        corner_i,
    output logic                 busy_o,
    output logic                 row_valid_o,
    output logic                 row_last_o,
    output logic [$clog2(N)-1:0] row_idx_o,
    output logic [N*SW-1:0]      row_data_o
);
    localparam int unsigned IW  = $clog2(N);
    localparam int unsigned GW  = SW + 7;
    localparam int unsigned SLW = GW - 2;
    localparam int unsigned AW  = SW + 12;
    localparam logic [IW-1:0] LAST_ROW = IW'(N - 1);

    plane_state_e state_q, state_d;

    logic [N*SW-1:0]       above_q, left_q;
    logic [SW-1:0]         corner_q;
    logic signed [GW-1:0]  h_comb, v_comb, h_q, v_q;
    logic signed [SLW-1:0] slope_b, slope_c;
    logic signed [AW-1:0]  base;
    logic [IW-1:0]         row_q;
    logic                  accept, acc_load, acc_step;

    assign accept = (state_q == ST_IDLE) && start;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_GRAD;
            ST_GRAD: state_d = ST_COEF;
            ST_COEF: state_d = ST_ROWS;
            ST_ROWS: if (row_q == LAST_ROW) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs and datapath controls
    always_comb begin
        busy_o      = 1'b0;
        row_valid_o = 1'b0;
        row_last_o  = 1'b0;
        acc_load    = 1'b0;
        acc_step    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_GRAD: busy_o = 1'b1;
            ST_COEF: begin
                busy_o   = 1'b1;
                acc_load = 1'b1;
            end
            ST_ROWS: begin
                busy_o      = 1'b1;
                row_valid_o = 1'b1;
                row_last_o  = (row_q == LAST_ROW);
                acc_step    = 1'b1;
            end
            default: ;
        endcase
    end

    assign row_idx_o = row_q;

    // neighbour capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            above_q  <= '0;
            left_q   <= '0;
            corner_q <= '0;
        end else if (accept) begin
            above_q  <= above_i;
            left_q   <= left_i;
            corner_q <= corner_i;
        end
    end

    // gradient register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= '0;
            v_q <= '0;
        end else if (state_q == ST_GRAD) begin
            h_q <= h_comb;
            v_q <= v_comb;
        end
    end

    // row counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q <= '0;
        end else if (acc_load) begin
            row_q <= '0;
        end else if (acc_step) begin
            row_q <= row_q + IW'(1);
        end
    end

    plane_grad #(.N(N), .SW(SW), .GW(GW)) u_grad_h (
        .samp_i   (above_q),
        .corner_i (corner_q),
        .grad_o   (h_comb)
    );

    plane_grad #(.N(N), .SW(SW), .GW(GW)) u_grad_v (
        .samp_i   (left_q),
        .corner_i (corner_q),
        .grad_o   (v_comb)
    );

    plane_coef #(.SW(SW), .GW(GW), .SLW(SLW), .AW(AW)) u_coef (
        .h_i        (h_q),
        .v_i        (v_q),
        .top_end_i  (above_q[(N-1)*SW +: SW]),
        .left_end_i (left_q[(N-1)*SW +: SW]),
        .b_o        (slope_b),
        .c_o        (slope_c),
        .base_o     (base)
    );

    plane_rowacc #(.N(N), .SW(SW), .SLW(SLW), .AW(AW)) u_rowacc (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (acc_load),
        .step_i (acc_step),
        .base_i (base),
        .b_i    (slope_b),
        .c_i    (slope_c),
        .row_o  (row_data_o)
    );
endmodule

// File: rtl/intra16_plane_chk.sv
module intra16_plane_chk #(
    parameter int unsigned IW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy_o,
    input logic          row_valid_o,
    input logic          row_last_o,
    input logic [IW-1:0] row_idx_o
);
    localparam logic [IW-1:0] LAST = '1;

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy_o) |-> ##3 (row_valid_o && row_idx_o == '0));

    assert_busy_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy_o) |=> (busy_o && !row_valid_o));

    assert_busy_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !row_last_o) |=> busy_o);

    assert_valid_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        row_valid_o |-> busy_o);

    assert_last_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
        row_last_o |-> (row_valid_o && row_idx_o == LAST));

    assert_row_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (row_valid_o && !row_last_o) |=> (row_valid_o && row_idx_o == $past(row_idx_o) + 1'b1));

    assert_end_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        row_last_o |=> !busy_o);

    assert_first_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(row_valid_o) |-> row_idx_o == '0);
endmodule

bind intra16_plane_pred intra16_plane_chk #(.IW($clog2(N))) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy_o      (busy_o),
    .row_valid_o (row_valid_o),
    .row_last_o  (row_last_o),
    .row_idx_o   (row_idx_o)
);

// File: tb/intra16_plane_pred_tb.sv
module intra16_plane_pred_tb;
    localparam int N = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [N*8-1:0] above_i = '0;
    logic [N*8-1:0] left_i = '0;
    logic [7:0]     corner_i = '0;
    logic           busy_o, row_valid_o, row_last_o;
    logic [3:0]     row_idx_o;
    logic [N*8-1:0] row_data_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int ea [N];
    int el [N];
    int ec;

    always #10 clk = ~clk;

    intra16_plane_pred u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .above_i(above_i), .left_i(left_i), .corner_i(corner_i),
        .busy_o(busy_o), .row_valid_o(row_valid_o), .row_last_o(row_last_o),
        .row_idx_o(row_idx_o), .row_data_o(row_data_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    function automatic int grad(input int s [N], input int cr);
        int g = 0;
        for (int k = 1; k <= 8; k++) begin
            g += k * (s[7+k] - ((k == 8) ? cr : s[7-k]));
        end
        return g;
    endfunction

    function automatic int ref_pix(input int x, input int y);
        int h, v, b, c, a, p;
        h = grad(ea, ec);
        v = grad(el, ec);
        b = (5*h + 32) >>> 6;
        c = (5*v + 32) >>> 6;
        a = 16 * (ea[15] + el[15]);
        p = (a + b*(x-7) + c*(y-7) + 16) >>> 5;
        if (p < 0) p = 0;
        if (p > 255) p = 255;
        return p;
    endfunction

    task automatic drive_nb();
        for (int i = 0; i < N; i++) begin
            above_i[i*8 +: 8] = 8'(ea[i]);
            left_i[i*8 +: 8]  = 8'(el[i]);
        end
        corner_i = 8'(ec);
    endtask

    // one prediction; optional start pulse with new neighbours mid-stream (R9)
    task automatic run_block(input bit disturb, input string tag);
        int mism, first_act, first_exp;
        @(negedge clk);
        drive_nb();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        above_i = {4{$urandom()}};
        left_i  = {4{$urandom()}};
        corner_i = 8'($urandom());
        chk(busy_o && !row_valid_o, "R2 busy after accept", {busy_o, row_valid_o}, 2);
        @(negedge clk);
        chk(!row_valid_o, "R2 no row yet", row_valid_o, 0);
        @(negedge clk);
        for (int y = 0; y < N; y++) begin
            chk(row_valid_o && row_idx_o == 4'(y), "R3 row index", row_idx_o, y);
            chk(row_last_o == (y == N-1), "R3 last flag", row_last_o, (y == N-1));
            chk(busy_o, "R2 busy held", busy_o, 1);
            mism = 0; first_act = 0; first_exp = 0;
            for (int x = 0; x < N; x++) begin
                if (int'(row_data_o[x*8 +: 8]) != ref_pix(x, y)) begin
                    if (mism == 0) begin
                        first_act = int'(row_data_o[x*8 +: 8]);
                        first_exp = ref_pix(x, y);
                    end
                    mism++;
                end
            end
            // R4 R5 R6 R7 R8: every sample against the plane formula
            chk(mism == 0, {"R6 samples ", tag}, first_act, first_exp);
            if (disturb && y == 5) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        chk(!busy_o && !row_valid_o, "R3 idle after last", busy_o, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int sat_lo, sat_hi;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        chk(!busy_o && !row_valid_o && !row_last_o, "R1 reset state", busy_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o, "R1 idle after reset", busy_o, 0);

        // flat block: identical rows (R8)
        for (int i = 0; i < N; i++) begin ea[i] = 128; el[i] = 128; end
        ec = 128;
        run_block(0, "flat");

        // steep ascending: clips at 255 (R7)
        for (int i = 0; i < N; i++) begin ea[i] = i * 17; el[i] = i * 17; end
        ec = 0;
        sat_hi = ref_pix(15, 15);
        chk(sat_hi == 255, "R7 bench corner high", sat_hi, 255);
        run_block(0, "ramp up");

        // steep descending: clips at 0 (R7)
        for (int i = 0; i < N; i++) begin ea[i] = 255 - i * 17; el[i] = 255 - i * 17; end
        ec = 255;
        sat_lo = ref_pix(15, 15);
        chk(sat_lo == 0, "R7 bench corner low", sat_lo, 0);
        run_block(0, "ramp down");

        // opposing gradients, negative V (R4 R5)
        for (int i = 0; i < N; i++) begin ea[i] = i * 16; el[i] = 255 - i * 16; end
        ec = 100;
        run_block(0, "cross");

        // disturbed stream: start and new neighbours ignored while busy (R9)
        for (int i = 0; i < N; i++) begin ea[i] = 30 + i * 5; el[i] = 200 - i * 3; end
        ec = 77;
        run_block(1, "R9 disturbed");

        // random neighbourhoods
        for (int t = 0; t < 24; t++) begin
            for (int i = 0; i < N; i++) begin
                ea[i] = int'($urandom_range(255, 0));
                el[i] = int'($urandom_range(255, 0));
            end
            ec = int'($urandom_range(255, 0));
            run_block(t % 6 == 5, "random");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule